// File: doc/BRIEF.md
# Keyed-Restart Watchdog Timer

This block is a countdown watchdog with a small word-addressed register bus. Software loads a reload value, arms the timer through a control register, and keeps it alive by writing one exact 32-bit key to a restart register. Any other value written there is dropped. While the timer is armed the counter steps down once per enabled cycle. The step is either a 1 MHz tick enable or every clock, depending on a control bit.

When the count reaches zero the block emits a one-cycle expiry event and latches a timeout flag. The counter then stays at zero until it is restarted. Depending on control bits, expiry also raises a sticky interrupt, a sticky reset request with a selectable target domain, and a sticky external-signal request. It can also latch a boot-from-secondary flag. While that flag is set, the two chip-select lines passing through the block are exchanged. A write to the clear register removes the timeout flag, the boot flag and the sticky requests.

Top module: `wdog_timer`

## Requirements
- R1: After reset the counter holds RELOAD_INIT, control reads 0, the timeout status reads 0, irq, rst_req, ext_req and expire_pulse are low, and cs_out equals cs_in.
- R2: A write of exactly 32'h0000_4755 to offset 0x08 loads the counter from the reload register at the next edge. Any other value written to 0x08 leaves the counter unchanged.
- R3: The counter decrements only while control bit 0 is 1. If control bit 4 is 1 it steps only in cycles where tick_1mhz is high, otherwise it steps every clock. With bit 0 at 0 the counter is frozen.
- R4: When a step takes the counter from 1 to 0, expire_pulse is high for exactly one cycle, aligned with the counter reading 0. Timeout status bit 0 becomes 1 and the counter stays at 0 until a restart.
- R5: At expiry, irq is set if control bit 2 is 1, rst_req if bit 1 is 1, and ext_req if bit 3 is 1. Each stays high until a valid restart or a clear write, and none is set if its bit is 0.
- R6: rst_target reflects control bits [6:5]: value 0 gives 0 (SoC), 1 gives 1 (full chip), 2 gives 2 (CPU only), and the unused value 3 gives 0.
- R7: At expiry with control bit 7 set, timeout status bit 1 becomes 1. While it is 1, cs_out[0] = cs_in[1] and cs_out[1] = cs_in[0].
- R8: Writing a word with bit 0 = 1 to offset 0x14 clears timeout status bits 1 and 0, irq, rst_req and ext_req, and restores direct chip-select mapping. A write with bit 0 = 0 has no effect. A clear while the mapping is already direct leaves it direct.
- R9: Reads return the live counter at 0x00, the reload value at 0x04, control bits [7:0] at 0x0C, and {boot flag, timeout flag} in bits [1:0] at 0x10. Offsets 0x08 and 0x14 read 0. Counter and reload are zero-extended to 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1mhz | input | 1 | 1 MHz step enable |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| cs_in | input | 2 | Chip-select lines from the flash controller |
| cs_out | output | 2 | Chip-select lines, exchanged while the boot flag is set |
| expire_pulse | output | 1 | One-cycle expiry event |
| irq | output | 1 | Sticky interrupt request |
| rst_req | output | 1 | Sticky reset request |
| rst_target | output | 2 | Reset domain: 0 SoC, 1 full chip, 2 CPU |
| ext_req | output | 1 | Sticky external-signal request |

## Verification
The bench builds the block with CNT_W = 16 and RELOAD_INIT = 0x100, with clock selection and chip-select swapping both enabled. The narrow counter makes the zero-extension and truncation of reload writes visible on readback. Small reload values then reach expiry within a few cycles. Because the clock-select variant is present, both the every-clock step and the tick-gated step can be exercised on the same build. Because the swap variant is present, cs_out can be checked before, during and after the boot flag.

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
package wdog_pkg;
   localparam int OFS_COUNT   = 0;
   localparam int OFS_RELOAD  = 4;
   localparam int OFS_RESTART = 8;
   localparam int OFS_CTRL    = 12;
   localparam int OFS_STAT    = 16;
   localparam int OFS_CLEAR   = 20;

   localparam int CB_EN   = 0;
   localparam int CB_RST  = 1;
   localparam int CB_IRQ  = 2;
   localparam int CB_EXT  = 3;
   localparam int CB_TICK = 4;
   localparam int CB_TGT  = 5;
   localparam int CB_BOOT = 7;

   typedef enum logic [1:0] {
      TGT_SOC  = 2'd0,
      TGT_CHIP = 2'd1,
      TGT_CPU  = 2'd2
   } wdog_tgt_e;

   function automatic wdog_tgt_e decode_target(input logic [1:0] f);
      case (f)
         2'd1:    decode_target = TGT_CHIP;
         2'd2:    decode_target = TGT_CPU;
         default: decode_target = TGT_SOC;
      endcase
   endfunction
endpackage

// File: rtl/wdog_regs.sv
`timescale 1ns/1ps
module wdog_regs
   import wdog_pkg::*;
#(
   parameter int          CNT_W       = 32,
   parameter int          ADDR_W      = 5,
   parameter logic [31:0] RELOAD_INIT = 32'h00FF_FFFF,
   parameter logic [31:0] KEY         = 32'h0000_4755
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   input  logic [CNT_W-1:0]  cnt,
   input  logic              tflag,
   input  logic              boot,
   output logic [31:0]       bus_rdata,
   output logic [CNT_W-1:0]  reload_q,
   output logic [7:0]        ctrl_q,
   output logic              restart_hit,
   output logic              clear_hit
);
   function automatic logic at(input int ofs);
      at = (bus_addr == ADDR_W'(ofs));
   endfunction

   assign restart_hit = bus_wr && at(OFS_RESTART) && (bus_wdata == KEY);
   assign clear_hit   = bus_wr && at(OFS_CLEAR) && bus_wdata[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reload_q <= RELOAD_INIT[CNT_W-1:0];
         ctrl_q   <= '0;
      end else if (bus_wr) begin
         if (at(OFS_RELOAD)) reload_q <= bus_wdata[CNT_W-1:0];
         if (at(OFS_CTRL))   ctrl_q   <= bus_wdata[7:0];
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (at(OFS_COUNT))  bus_rdata = 32'(cnt);
      if (at(OFS_RELOAD)) bus_rdata = 32'(reload_q);
      if (at(OFS_CTRL))   bus_rdata = 32'(ctrl_q);
      if (at(OFS_STAT))   bus_rdata = {30'd0, boot, tflag};
   end
endmodule

// File: rtl/wdog_counter.sv
`timescale 1ns/1ps
module wdog_counter #(
   parameter int          CNT_W       = 32,
   parameter logic [31:0] RELOAD_INIT = 32'h00FF_FFFF,
   parameter bit          HAS_CLK_SEL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             tick_sel,
   input  logic             tick,
   input  logic             restart,
   input  logic [CNT_W-1:0] reload,
   output logic [CNT_W-1:0] cnt_q,
   output logic             expire
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
   logic step;

   generate
      if (HAS_CLK_SEL) begin : g_sel
         assign step = enable && (tick_sel ? tick : 1'b1);
      end else begin : g_tick_only
         logic unused_sel;
         assign unused_sel = tick_sel;
         assign step = enable && tick;
      end
   endgenerate

   assign expire = step && !restart && (cnt_q == ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= RELOAD_INIT[CNT_W-1:0];
      else if (restart)
         cnt_q <= reload;
      else if (step && cnt_q != '0)
         cnt_q <= cnt_q - ONE;
   end
endmodule

// File: rtl/wdog_expiry.sv
`timescale 1ns/1ps
module wdog_expiry
   import wdog_pkg::*;
#(
   parameter bit SWAP_CS = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       expire,
   input  logic       restart,
   input  logic       clear,
   input  logic [7:0] ctrl,
   input  logic [1:0] cs_in,
   output logic [1:0] cs_out,
   output logic       expire_pulse,
   output logic       tflag_q,
   output logic       boot_q,
   output logic       irq,
   output logic       rst_req,
   output logic       ext_req
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         expire_pulse <= 1'b0;
         tflag_q      <= 1'b0;
         irq          <= 1'b0;
         rst_req      <= 1'b0;
         ext_req      <= 1'b0;
      end else begin
         expire_pulse <= expire;
         if (expire)     tflag_q <= 1'b1;
         else if (clear) tflag_q <= 1'b0;
         if (expire && ctrl[CB_IRQ])  irq <= 1'b1;
         else if (restart || clear)   irq <= 1'b0;
         if (expire && ctrl[CB_RST])  rst_req <= 1'b1;
         else if (restart || clear)   rst_req <= 1'b0;
         if (expire && ctrl[CB_EXT])  ext_req <= 1'b1;
         else if (restart || clear)   ext_req <= 1'b0;
      end
   end

   generate
      if (SWAP_CS) begin : g_swap
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                        boot_q <= 1'b0;
            else if (expire && ctrl[CB_BOOT])  boot_q <= 1'b1;
            else if (clear)                    boot_q <= 1'b0;
         end
         assign cs_out = boot_q ? {cs_in[0], cs_in[1]} : cs_in;
      end else begin : g_direct
         assign boot_q = 1'b0;
         assign cs_out = cs_in;
      end
   endgenerate
endmodule

// File: rtl/wdog_timer.sv
`timescale 1ns/1ps
module wdog_timer
   import wdog_pkg::*;
#(
   parameter int          CNT_W       = 32,
   parameter int          ADDR_W      = 5,
   parameter logic [31:0] RELOAD_INIT = 32'h00FF_FFFF,
   parameter logic [31:0] KEY         = 32'h0000_4755,
   parameter bit          HAS_CLK_SEL = 1'b1,
   parameter bit          SWAP_CS     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_1mhz,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [1:0]        cs_in,
   output logic [1:0]        cs_out,
   output logic              expire_pulse,
   output logic              irq,
   output logic              rst_req,
   output logic [1:0]        rst_target,
   output logic              ext_req
);
   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt
         $error("wdog_timer: CNT_W must lie in 2..32");
      end
      if (ADDR_W < 5) begin : g_bad_addr
         $error("wdog_timer: ADDR_W must be at least 5");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q, reload_q;
   logic [7:0]       ctrl_q;
   logic             restart_hit, clear_hit, expire_now;
   logic             tflag_q, boot_q;

   wdog_regs #(
      .CNT_W(CNT_W), .ADDR_W(ADDR_W), .RELOAD_INIT(RELOAD_INIT), .KEY(KEY)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .cnt(cnt_q), .tflag(tflag_q), .boot(boot_q),
      .bus_rdata(bus_rdata), .reload_q(reload_q), .ctrl_q(ctrl_q),
      .restart_hit(restart_hit), .clear_hit(clear_hit)
   );

   wdog_counter #(
      .CNT_W(CNT_W), .RELOAD_INIT(RELOAD_INIT), .HAS_CLK_SEL(HAS_CLK_SEL)
   ) u_cnt (
      .clk(clk), .rst_n(rst_n), .enable(ctrl_q[CB_EN]),
      .tick_sel(ctrl_q[CB_TICK]), .tick(tick_1mhz), .restart(restart_hit),
      .reload(reload_q), .cnt_q(cnt_q), .expire(expire_now)
   );

   wdog_expiry #(.SWAP_CS(SWAP_CS)) u_exp (
      .clk(clk), .rst_n(rst_n), .expire(expire_now), .restart(restart_hit),
      .clear(clear_hit), .ctrl(ctrl_q), .cs_in(cs_in), .cs_out(cs_out),
      .expire_pulse(expire_pulse), .tflag_q(tflag_q), .boot_q(boot_q),
      .irq(irq), .rst_req(rst_req), .ext_req(ext_req)
   );

   assign rst_target = decode_target(ctrl_q[CB_TGT+1:CB_TGT]);
endmodule

// File: rtl/wdog_timer_chk.sv
`timescale 1ns/1ps
module wdog_timer_chk #(
   parameter int          CNT_W  = 32,
   parameter int          ADDR_W = 5,
   parameter logic [31:0] KEY    = 32'h0000_4755
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_wdata,
   input logic [CNT_W-1:0]  cnt,
   input logic [CNT_W-1:0]  reload,
   input logic              armed,
   input logic              expire_pulse,
   input logic              tflag,
   input logic              boot_sec,
   input logic              irq,
   input logic [1:0]        cs_in,
   input logic [1:0]        cs_out
);
   logic wr_restart, wr_clear;
   assign wr_restart = bus_wr && bus_addr == ADDR_W'(8);
   assign wr_clear   = bus_wr && bus_addr == ADDR_W'(20) && bus_wdata[0];

   // R2
   restart_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_restart && bus_wdata == KEY) |=> cnt == $past(reload));
   // R2
   restart_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_restart && bus_wdata != KEY && !armed) |=> $stable(cnt));
   // R3
   freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed && !wr_restart) |=> $stable(cnt));
   // R4
   expire_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      expire_pulse |=> !expire_pulse);
   // R4
   expire_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      expire_pulse |-> (cnt == '0 && tflag));
   // R5
   irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> tflag);
   // R7
   swap_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
      boot_sec |-> cs_out == {cs_in[0], cs_in[1]});
   // R8
   direct_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !boot_sec |-> cs_out == cs_in);
   // R8
   clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_clear |=> ((!boot_sec && !irq) || expire_pulse));
endmodule

bind wdog_timer wdog_timer_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .KEY(KEY)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata), .cnt(cnt_q), .reload(reload_q), .armed(ctrl_q[0]),
   .expire_pulse(expire_pulse), .tflag(tflag_q), .boot_sec(boot_q),
   .irq(irq), .cs_in(cs_in), .cs_out(cs_out)
);

// File: tb/wdog_timer_bench.sv
`timescale 1ns/1ps
module wdog_timer_bench;
   localparam int CNT_W  = 16;
   localparam int ADDR_W = 5;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              tick_1mhz = 1'b0;
   logic              bus_wr = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic [31:0]       bus_wdata = '0;
   logic [31:0]       bus_rdata;
   logic [1:0]        cs_in = 2'b01;
   logic [1:0]        cs_out;
   logic              expire_pulse, irq, rst_req, ext_req;
   logic [1:0]        rst_target;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   wdog_timer #(
      .CNT_W(CNT_W), .ADDR_W(ADDR_W), .RELOAD_INIT(32'h0000_0100)
   ) u_wdog_timer (
      .clk(clk), .rst_n(rst_n), .tick_1mhz(tick_1mhz), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .cs_in(cs_in), .cs_out(cs_out), .expire_pulse(expire_pulse),
      .irq(irq), .rst_req(rst_req), .rst_target(rst_target), .ext_req(ext_req)
   );

   always #2.5 clk = ~clk;

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic wr(input int ofs, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = ADDR_W'(ofs); bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
   endtask

   task automatic rd(input int ofs, output logic [31:0] d);
      bus_addr = ADDR_W'(ofs);
      #1 d = bus_rdata;
      bus_addr = '0;
   endtask

   task automatic arm(input logic [31:0] rl, input logic [31:0] c);
      wr(12, 32'h0);
      wr(4, rl);
      wr(8, 32'h0000_4755);
      wr(12, c);
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rd(0, v);  check("R1", "counter", v, 32'h100);
      rd(12, v); check("R1", "control", v, 32'h0);
      rd(16, v); check("R1", "status", v, 32'h0);
      check("R1", "outputs", {28'd0, irq, rst_req, ext_req, expire_pulse}, 32'h0);
      check("R1", "cs", 32'(cs_out), 32'(cs_in));
   endtask

   task automatic t_restart_key();
      logic [31:0] v;
      wr(4, 32'd20);
      wr(8, 32'h0000_1234);
      rd(0, v); check("R2", "bad key", v, 32'h100);
      wr(8, 32'h0001_4755);
      rd(0, v); check("R2", "key with upper bits", v, 32'h100);
      wr(8, 32'h0000_4755);
      rd(0, v); check("R2", "good key", v, 32'd20);
   endtask

   task automatic t_freeze();
      logic [31:0] v;
      repeat (5) @(negedge clk);
      rd(0, v); check("R3", "frozen while disabled", v, 32'd20);
   endtask

   task automatic t_count_expire();
      logic [31:0] v;
      arm(32'd6, 32'h0F);
      for (int k = 1; k <= 5; k++) begin
         @(negedge clk);
         rd(0, v); check("R3", "decrement", v, 32'(6 - k));
         check("R4", "no early pulse", 32'(expire_pulse), 32'h0);
      end
      @(negedge clk);
      rd(0, v); check("R4", "reaches zero", v, 32'h0);
      check("R4", "pulse", 32'(expire_pulse), 32'h1);
      rd(16, v); check("R4", "timeout flag", v, 32'h1);
      @(negedge clk);
      check("R4", "pulse one cycle", 32'(expire_pulse), 32'h0);
      repeat (3) @(negedge clk);
      rd(0, v); check("R4", "hold at zero", v, 32'h0);
      check("R5", "irq/rst/ext set", {29'd0, irq, rst_req, ext_req}, 32'h7);
      wr(8, 32'h0000_4755);
      check("R5", "restart clears requests", {29'd0, irq, rst_req, ext_req}, 32'h0);
      rd(16, v); check("R4", "flag survives restart", v, 32'h1);
      repeat (6) @(negedge clk);
      check("R5", "irq again", 32'(irq), 32'h1);
      wr(20, 32'h1);
      check("R5", "clear drops requests", {29'd0, irq, rst_req, ext_req}, 32'h0);
      rd(16, v); check("R8", "clear drops flag", v, 32'h0);
      wr(12, 32'h0);
   endtask

   task automatic t_tick();
      logic [31:0] v;
      arm(32'd50, 32'h11);
      repeat (5) @(negedge clk);
      rd(0, v); check("R3", "no tick no step", v, 32'd50);
      tick_1mhz = 1'b1;
      repeat (3) @(negedge clk);
      tick_1mhz = 1'b0;
      rd(0, v); check("R3", "tick steps", v, 32'd47);
      wr(12, 32'h0);
   endtask

   task automatic t_target();
      wr(12, 32'h00); check("R6", "soc", 32'(rst_target), 32'd0);
      wr(12, 32'h20); check("R6", "chip", 32'(rst_target), 32'd1);
      wr(12, 32'h40); check("R6", "cpu", 32'(rst_target), 32'd2);
      wr(12, 32'h60); check("R6", "unused code", 32'(rst_target), 32'd0);
      wr(12, 32'h00);
   endtask

   task automatic t_boot();
      logic [31:0] v;
      arm(32'd3, 32'h81);
      repeat (3) @(negedge clk);
      rd(16, v); check("R7", "boot+timeout status", v, 32'h3);
      check("R7", "cs swapped", 32'(cs_out), 32'h2);
      check("R5", "irq off when disabled", 32'(irq), 32'h0);
      wr(20, 32'h0);
      rd(16, v); check("R8", "clear bit0=0 ignored", v, 32'h3);
      check("R8", "still swapped", 32'(cs_out), 32'h2);
      wr(20, 32'h1);
      rd(16, v); check("R8", "clear status", v, 32'h0);
      check("R8", "direct map", 32'(cs_out), 32'h1);
      wr(12, 32'h0);
      wr(20, 32'h1);
      check("R8", "clear when direct", 32'(cs_out), 32'h1);
   endtask

   task automatic t_reads();
      logic [31:0] v;
      wr(4, 32'h1234_ABCD);
      rd(4, v);  check("R9", "reload truncated", v, 32'h0000_ABCD);
      wr(12, 32'hFFFF_FF0E);
      rd(12, v); check("R9", "control low byte", v, 32'h0E);
      rd(8, v);  check("R9", "restart reads 0", v, 32'h0);
      rd(20, v); check("R9", "clear reads 0", v, 32'h0);
      wr(12, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_restart_key();
      t_freeze();
      t_count_expire();
      t_tick();
      t_target();
      t_boot();
      t_reads();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule